// File: doc/BRIEF.md
# Inbound Interrupt Message Capture Queue

This block sits on the inbound side of a host bridge and turns memory-write style interrupt messages into a level interrupt for a local processor. Every inbound write presents a 64-bit address and a 32-bit data word. When capture is armed and the address falls inside a programmed target region, the block stores the data word together with the full address as one queue entry. Writes outside the region, or writes that arrive while capture is disarmed, are ignored.

A single interrupt line stays high while the queue holds at least one entry and capture is armed. Software drains the queue one entry at a time. It reads the head entry's data word and the low and high halves of its address through a small register port. The head entry is released only once all three words have been read, in whatever order software chooses. A write that meets a full queue is lost, and a sticky overflow flag records the loss. In normal use the region is programmed to 4096 bytes, and vector n is raised by writing the value n to region base + 4*n.

Top module: `msi_rx_queue`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: An inbound write is captured only when base <= address < base + size, where base is the 64-bit value at offsets 0x04 (bits 31:0) and 0x08 (bits 63:32) and size is the 32-bit value at 0x0C. Writes at base - 4 or at exactly base + size are ignored.
- R3: While the enable register (offset 0x14, bit 0) is 0, inbound writes are ignored.
- R4: Offsets 0x20, 0x24 and 0x28 return the head entry's data word, address bits 31:0 and address bits 63:32. Entries leave the queue in arrival order.
- R5: The head entry is released in the cycle of the read that completes the set of data, address-low and address-high reads, in any order. A repeated read of the same word does not count twice, and until the set is complete the same head stays visible.
- R6: Status (offset 0x18) bit 0 reads 1 exactly while at least one entry is queued.
- R7: While the queue is empty, reads of 0x20, 0x24 and 0x28 return zero and leave no trace, so a later entry still needs all three reads.
- R8: The queue holds 16 entries. A captured write that meets a full queue is dropped and sets status bit 1. That bit stays set until software writes 1 to status bit 1, and writing 0 there leaves it unchanged.
- R9: `irq_o` equals status bit 0 AND the enable bit. Clearing the enable bit does not discard queued entries.
- R10: The base, size and enable registers read back the values last written to them. Register reads are combinational in the cycle that `reg_rd_i` is high, and writes take effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_wr_i | input | 1 | Inbound message write strobe |
| msg_addr_i | input | 64 | Inbound write address |
| msg_data_i | input | 32 | Inbound write data |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid while reg_rd_i is high |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench targets the region edges at base - 4, base + 4092 and base + size. A design with an off-by-one compare would capture the write at base + size or miss the last vector. It drains entries in shuffled orders with repeated reads, and it issues reads on an empty queue before a push. A design that counted a repeat, or that kept read marks across an empty period, would release an entry early and show the next head or zero too soon. The bench also fills the queue past 16 entries and toggles the enable bit while entries are queued. This exposes a lost or non-sticky overflow flag, a mis-ordered drain, or an interrupt that ignores the enable bit.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_BASE_LO = 8'h04;
  localparam logic [REG_AW-1:0] OFS_BASE_HI = 8'h08;
  localparam logic [REG_AW-1:0] OFS_SIZE    = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_ENABLE  = 8'h14;
  localparam logic [REG_AW-1:0] OFS_STATUS  = 8'h18;
  localparam logic [REG_AW-1:0] OFS_DATA    = 8'h20;
  localparam logic [REG_AW-1:0] OFS_ADDR_LO = 8'h24;
  localparam logic [REG_AW-1:0] OFS_ADDR_HI = 8'h28;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] addr;
  } msg_entry_t;
endpackage

// File: rtl/msi_rx_window.sv
module msi_rx_window
  import msi_rx_pkg::*;
(
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DATA_W-1:0] size_i,
  input  logic              en_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] offset;
  logic              above_base;
  logic              below_top;

  // offset compare avoids base + size wrapping past 2^64
  assign offset     = addr_i - base_i;
  assign above_base = (addr_i >= base_i);
  assign below_top  = (offset < {{(ADDR_W-DATA_W){1'b0}}, size_i});
  assign hit_o      = wr_i & en_i & above_base & below_top;
endmodule

// File: rtl/msi_rx_fifo.sv
module msi_rx_fifo
  import msi_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_req_i,
  input  msg_entry_t entry_i,
  input  logic       pop_i,
  output msg_entry_t head_o,
  output logic       empty_o,
  output logic       drop_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  msg_entry_t    mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          full, push;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push    = push_req_i & ~full;
  assign drop_o  = push_req_i & full;
  assign head_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (push) begin
      mem_q[wr_ptr_q] <= entry_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i) rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_pop_nonempty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1)));
endmodule

// File: rtl/msi_rx_drain.sv
module msi_rx_drain
  import msi_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_rd_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              empty_i,
  output logic              pop_o
);
  localparam int unsigned NWORDS = 3;
  localparam logic [REG_AW-1:0] WORD_OFS [NWORDS] = '{OFS_DATA, OFS_ADDR_LO, OFS_ADDR_HI};

  logic [NWORDS-1:0] seen_q, seen_nxt, hit;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign hit[w] = reg_rd_i & ~empty_i & (reg_addr_i == WORD_OFS[w]);
  end

  assign seen_nxt = seen_q | hit;
  assign pop_o    = (|hit) & (&seen_nxt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seen_q <= '0;
    else if (pop_o) seen_q <= '0;
    else            seen_q <= seen_nxt;
  end

  assert_pop_after_three_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> ($countones(seen_q) == NWORDS - 1));
  assert_empty_no_marks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_i |-> (seen_q == '0));
endmodule

// File: rtl/msi_rx_regs.sv
module msi_rx_regs
  import msi_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              ovf_set_i,
  input  logic              empty_i,
  input  msg_entry_t        head_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [DATA_W-1:0] size_o,
  output logic              en_o
);
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] size_q;
  logic              en_q, ovf_q, ovf_clr;

  assign ovf_clr = reg_wr_i & (reg_addr_i == OFS_STATUS) & reg_wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      size_q <= '0;
      en_q   <= 1'b0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        OFS_BASE_LO: base_q[DATA_W-1:0]      <= reg_wdata_i;
        OFS_BASE_HI: base_q[ADDR_W-1:DATA_W] <= reg_wdata_i;
        OFS_SIZE:    size_q                  <= reg_wdata_i;
        OFS_ENABLE:  en_q                    <= reg_wdata_i[0];
        default: ;
      endcase
    end
  end

  // a new drop in the clearing cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (ovf_set_i) ovf_q <= 1'b1;
    else if (ovf_clr)   ovf_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (reg_addr_i)
      OFS_BASE_LO: rdata_o = base_q[DATA_W-1:0];
      OFS_BASE_HI: rdata_o = base_q[ADDR_W-1:DATA_W];
      OFS_SIZE:    rdata_o = size_q;
      OFS_ENABLE:  rdata_o = {{(DATA_W-1){1'b0}}, en_q};
      OFS_STATUS:  rdata_o = {{(DATA_W-2){1'b0}}, ovf_q, ~empty_i};
      OFS_DATA:    rdata_o = empty_i ? '0 : head_i.data;
      OFS_ADDR_LO: rdata_o = empty_i ? '0 : head_i.addr[DATA_W-1:0];
      OFS_ADDR_HI: rdata_o = empty_i ? '0 : head_i.addr[ADDR_W-1:DATA_W];
      default:     rdata_o = '0;
    endcase
  end

  assign base_o = base_q;
  assign size_o = size_q;
  assign en_o   = en_q;

  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr) |=> ovf_q);
endmodule

// File: rtl/msi_rx_queue.sv
module msi_rx_queue
  import msi_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        msg_wr_i,
  input  logic [63:0] msg_addr_i,
  input  logic [31:0] msg_data_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);
  logic [ADDR_W-1:0] base;
  logic [DATA_W-1:0] size;
  logic              en, win_hit, empty, drop, pop;
  msg_entry_t        head, new_entry;

  assign new_entry = '{data: msg_data_i, addr: msg_addr_i};

  msi_rx_window u_window (
    .wr_i   (msg_wr_i),
    .addr_i (msg_addr_i),
    .base_i (base),
    .size_i (size),
    .en_i   (en),
    .hit_o  (win_hit)
  );

  msi_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_req_i (win_hit),
    .entry_i    (new_entry),
    .pop_i      (pop),
    .head_o     (head),
    .empty_o    (empty),
    .drop_o     (drop)
  );

  msi_rx_drain u_drain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_rd_i   (reg_rd_i),
    .reg_addr_i (reg_addr_i),
    .empty_i    (empty),
    .pop_o      (pop)
  );

  msi_rx_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .ovf_set_i   (drop),
    .empty_i     (empty),
    .head_i      (head),
    .rdata_o     (reg_rdata_o),
    .base_o      (base),
    .size_o      (size),
    .en_o        (en)
  );

  assign irq_o = ~empty & en;

  assert_capture_needs_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_hit |-> en);
  assert_irq_rise_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(msg_wr_i) || $past(reg_wr_i)));
endmodule

// File: tb/msi_rx_queue_tb.sv
module msi_rx_queue_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        msg_wr_i = 1'b0;
  logic [63:0] msg_addr_i = '0;
  logic [31:0] msg_data_i = '0;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  msi_rx_queue u_dut (.*);

  always #10 clk_i = ~clk_i;

  int nvec = 0, nmis = 0;
  bit run = 0, done = 0;

  // reference model
  logic [95:0] m_q[$];
  logic [63:0] m_base = '0;
  logic [31:0] m_size = '0;
  bit          m_en = 0, m_ovf = 0;
  bit [2:0]    m_seen = '0;

  localparam logic [63:0] BASE = 64'h0000_0001_FEE0_0000;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [95:0] h;
    h = (m_q.size() > 0) ? m_q[0] : '0;
    case (a)
      8'h04: return m_base[31:0];
      8'h08: return m_base[63:32];
      8'h0C: return m_size;
      8'h14: return {31'b0, m_en};
      8'h18: return {30'b0, m_ovf, m_q.size() > 0};
      8'h20: return h[95:64];
      8'h24: return h[31:0];
      8'h28: return h[63:32];
      default: return '0;
    endcase
  endfunction

  always @(negedge clk_i)
    if (run) chk("R9 irq", {63'b0, irq_o}, {63'b0, (m_q.size() > 0) && m_en});

  task automatic msg(logic [63:0] a, logic [31:0] d);
    longint unsigned ua, ub;
    msg_wr_i = 1; msg_addr_i = a; msg_data_i = d;
    @(posedge clk_i);
    ua = a; ub = m_base;
    if (m_en && ua >= ub && (ua - ub) < {32'b0, m_size}) begin
      if (m_q.size() < 16) m_q.push_back({d, a});
      else m_ovf = 1;
    end
    @(negedge clk_i);
    msg_wr_i = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] v);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = v;
    @(posedge clk_i);
    case (a)
      8'h04: m_base[31:0] = v;
      8'h08: m_base[63:32] = v;
      8'h0C: m_size = v;
      8'h14: m_en = v[0];
      8'h18: if (v[1]) m_ovf = 0;
      default: ;
    endcase
    @(negedge clk_i);
    reg_wr_i = 0;
  endtask

  task automatic rd(string tag, logic [7:0] a);
    reg_rd_i = 1; reg_addr_i = a;
    #2;
    chk(tag, {32'b0, reg_rdata_o}, {32'b0, m_read(a)});
    @(posedge clk_i);
    if (m_q.size() > 0) begin
      if (a == 8'h20) m_seen[0] = 1;
      if (a == 8'h24) m_seen[1] = 1;
      if (a == 8'h28) m_seen[2] = 1;
      if (m_seen == 3'b111) begin
        void'(m_q.pop_front());
        m_seen = '0;
      end
    end
    @(negedge clk_i);
    reg_rd_i = 0;
  endtask

  task automatic drain_one(string tag);
    rd(tag, 8'h20);
    rd(tag, 8'h24);
    rd(tag, 8'h28);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nmis++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    run = 1;
    @(negedge clk_i);
    // R1 reset state
    rd("R1 status", 8'h18);
    rd("R1 enable", 8'h14);
    rd("R1 base_lo", 8'h04);
    rd("R1 size", 8'h0C);
    chk("R1 irq", {63'b0, irq_o}, 64'd0);

    wr(8'h04, BASE[31:0]);
    wr(8'h08, BASE[63:32]);
    wr(8'h0C, 32'd4096);
    // R3 disabled capture
    msg(BASE, 32'h5);
    rd("R3 status disabled", 8'h18);
    chk("R3 queue empty", {63'b0, irq_o}, 64'd0);
    wr(8'h14, 32'h1);
    // R10 readback
    rd("R10 base_lo", 8'h04);
    rd("R10 base_hi", 8'h08);
    rd("R10 size", 8'h0C);
    rd("R10 enable", 8'h14);

    // R2 vectors and boundaries
    for (int n = 0; n < 4; n++) msg(BASE + 64'(4 * n), 32'(n));
    msg(BASE - 64'd4, 32'hBAD0);
    msg(BASE + 64'd4096, 32'hBAD1);
    msg(64'h0, 32'hBAD2);
    msg(BASE + 64'd4092, 32'h3FF);
    rd("R6 status nonempty", 8'h18);

    // R4 in-order drain of first entry, R5 head held
    rd("R4 data", 8'h20);
    rd("R4 addr_lo", 8'h24);
    rd("R5 head held", 8'h20);
    rd("R5 status held", 8'h18);
    rd("R4 addr_hi", 8'h28);
    // R5 shuffled with repeats
    rd("R5 hi", 8'h28);
    rd("R5 hi again", 8'h28);
    rd("R5 data", 8'h20);
    rd("R5 lo", 8'h24);
    rd("R5 next head", 8'h20);
    drain_one("R4 drain");
    drain_one("R4 drain");
    drain_one("R2 last vector");
    rd("R6 status empty", 8'h18);

    // R7 empty reads
    rd("R7 data empty", 8'h20);
    rd("R7 lo empty", 8'h24);
    rd("R7 hi empty", 8'h28);
    msg(BASE + 64'd8, 32'h2);
    rd("R7 data", 8'h20);
    rd("R7 lo", 8'h24);
    rd("R7 still queued", 8'h18);
    rd("R7 hi", 8'h28);
    rd("R7 status after", 8'h18);

    // R8 overflow
    for (int i = 0; i < 17; i++) msg(BASE + 64'(4 * (i % 16)), 32'(100 + i));
    rd("R8 status ovf", 8'h18);
    wr(8'h18, 32'h0);
    rd("R8 ovf sticky", 8'h18);
    wr(8'h18, 32'h2);
    rd("R8 ovf cleared", 8'h18);

    // R9 enable gating
    wr(8'h14, 32'h0);
    chk("R9 irq disabled", {63'b0, irq_o}, 64'd0);
    rd("R9 status kept", 8'h18);
    msg(BASE, 32'hDEAD);
    wr(8'h14, 32'h1);
    for (int i = 0; i < 16; i++) drain_one("R8 order");
    rd("R8 status drained", 8'h18);
    rd("R10 size end", 8'h0C);

    run = 0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule